// File: doc/BRIEF.md
# Programmable PCM Serial Output Transmitter

This block turns a stream of stereo sample pairs into a three-wire serial PCM stream: a data line, a bit clock and a left/right word clock. All three are produced in the domain of an oversampling master clock. The bit clock is derived from it through a programmable divider, so one bit period lasts `2*(1+div)` master cycles. Each channel occupies a slot of 16 or 32 bit periods, and one frame holds a left slot followed by a right slot.

Configuration inputs set four things: the slot width, the bit order (MSB or LSB first), the bit-clock polarity (which edge moves the data line), and the framing. The framing is either the standard I2S layout, with the word clock leading the data by one bit, or a left-justified layout. The sample source offers a pair with a valid flag. The block takes the pair in the single cycle in which it raises ready at the end of each frame. When no pair is offered at that point, the next frame carries zeros. The configuration inputs are expected to change only while reset is held.

Top module: `pcm_serial_tx`

## Requirements
- R1: One bit period lasts exactly `2*(1+div)` master clock cycles, and the bit clock holds each of its two levels for `1+div` cycles.
- R2: A frame is a left slot followed by a right slot. A slot is 16 bit periods when `cfg_wide`=0 and 32 bit periods when `cfg_wide`=1. The ready pulses are therefore `2*S*2*(1+div)` master cycles apart, where S is the slot length.
- R3: With `cfg_lsb_first`=0 the most significant slot bit is sent first. With `cfg_lsb_first`=1 bit 0 of the slot is sent first.
- R4: With `cfg_sck_inv`=0 the data line changes when the bit clock falls and is stable across its rising edge. With `cfg_sck_inv`=1 the roles of the two edges are swapped.
- R5: With `cfg_left_just`=0 (I2S), the word clock is 0 during the left channel and 1 during the right channel. It toggles one bit period before the first bit of each slot.
- R6: With `cfg_left_just`=1, the word clock is 1 for the left slot and 0 for the right slot. It toggles in the same bit period as the first bit of each slot.
- R7: `s_ready` is high for exactly one master cycle, the last cycle of each frame. A pair with `s_valid`=1 in that cycle is sent in the following frame.
- R8: If `s_valid` is 0 in the ready cycle, the following frame carries zeros in both slots, whatever values sit on the sample inputs.
- R9: In 32-bit slots the 16-bit sample fills slot bits 31..16 and slot bits 15..0 are zero.
- R10: While reset is held, `sdo` is 0, `sck` equals `cfg_sck_inv`, and `lrck` equals `cfg_left_just`. After reset the first bit period is the first bit of a left slot, and the first frame is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div | input | DIV_W | Bit-clock divider; half bit period is 1+div master cycles |
| cfg_wide | input | 1 | 0: 16-bit slots, 1: 32-bit slots |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_sck_inv | input | 1 | Bit-clock polarity select |
| cfg_left_just | input | 1 | 0: I2S framing, 1: left-justified framing |
| s_valid | input | 1 | A stereo pair is offered |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| s_ready | output | 1 | One-cycle pulse when the pair is taken |
| sdo | output | 1 | Serial data |
| sck | output | 1 | Bit clock |
| lrck | output | 1 | Word (left/right) clock |

## Verification
A divider count that slips shows up within one bit period as a bit-clock level held for the wrong number of master cycles. A bit-position counter that goes off track misplaces the word-clock edge, or the first sample bit, within the same frame. That error then repeats in every later frame, because a new pair is only ever taken at the frame boundary. A fault in the sample latch or the slot selection shows up as wrong serial bits in the frame that follows the handshake. The bench decodes every bit at the data-sampling edge of the bit clock.

// File: rtl/pcm_tx_pkg.sv
// Package: shared defaults and the configuration bundle of the PCM transmitter.
// Assumes: samples are two's complement words of SAMPLE_W_DEF bits.
package pcm_tx_pkg;
    localparam int SAMPLE_W_DEF = 16;
    localparam int DIV_W_DEF    = 8;

    typedef struct packed {
        logic wide;       // 32-bit slots when set
        logic lsb_first;  // bit order
        logic sck_inv;    // bit clock polarity
        logic left_just;  // framing select
    } pcm_cfg_t;
endpackage

// File: rtl/pcm_clk_div.sv
// Module: bit-clock divider. Produces the bit-clock phase (0 = first half of
// a bit period, 1 = second half) and a one-cycle tick at the end of each bit.
// Assumes: div is stable outside reset.
module pcm_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             bit_end
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap    = (cnt_q >= div);
    assign bit_end = wrap & phase;

    // Count master cycles of each half period; flip the phase on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > div) |=> (cnt_q == '0)); // R1
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < div) |=> $stable(phase)); // R1
endmodule

// File: rtl/pcm_frame_seq.sv
// Module: frame sequencer. Tracks the bit position within a frame, marks the
// frame end and derives the word clock for either framing.
// Assumes: wide and left_just change only during reset.
module pcm_frame_seq #(
    parameter int SAMPLE_W = 16,
    parameter int BIT_W    = $clog2(4*SAMPLE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_end,
    input  logic             wide,
    input  logic             left_just,
    output logic [BIT_W-1:0] bidx,
    output logic             in_left,
    output logic             lrck,
    output logic             frame_end
);
    logic [BIT_W-1:0] slot_len;
    logic [BIT_W-1:0] last_idx;
    logic             i2s_right;

    assign slot_len  = wide ? BIT_W'(2*SAMPLE_W)   : BIT_W'(SAMPLE_W);
    assign last_idx  = wide ? BIT_W'(4*SAMPLE_W-1) : BIT_W'(2*SAMPLE_W-1);
    assign frame_end = bit_end && (bidx >= last_idx);
    assign in_left   = (bidx < slot_len);

    // Advance the bit position at every bit end, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         bidx <= '0;
        else if (frame_end) bidx <= '0;
        else if (bit_end)   bidx <= bidx + 1'b1;
    end

    // Word clock: I2S leads the slot by one bit, left-justified is aligned.
    always_comb begin
        i2s_right = (bidx >= slot_len - 1'b1) && (bidx < last_idx);
        lrck      = left_just ? in_left : i2s_right;
    end

    AST_LRCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lrck) && $stable(wide) && $stable(left_just)) |-> $past(bit_end)); // R5
endmodule

// File: rtl/pcm_slot_mux.sv
// Module: sample latch and slot bit selector. Holds the pair for the current
// frame and picks the serial bit for the current bit position and bit order.
// Assumes: load is a one-cycle pulse at the frame end.
module pcm_slot_mux #(
    parameter int SAMPLE_W = 16,
    parameter int BIT_W    = $clog2(4*SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic [BIT_W-1:0]    bidx,
    input  logic                in_left,
    input  logic                wide,
    input  logic                lsb_first,
    output logic                sdo
);
    localparam int WORD_W = 2*SAMPLE_W;
    localparam int POS_W  = $clog2(WORD_W);

    logic [SAMPLE_W-1:0] l_q, r_q, cur;
    logic [WORD_W-1:0]   word;
    logic [BIT_W-1:0]    slot_len, k_full;
    logic [POS_W-1:0]    k, slot_top, pos;

    // Latch the offered pair at the frame end, or zeros when none is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
            r_q <= '0;
        end else if (load) begin
            l_q <= take ? left_in  : '0;
            r_q <= take ? right_in : '0;
        end
    end

    // Select the channel, place it in its slot and pick the bit to send.
    always_comb begin
        cur      = in_left ? l_q : r_q;
        slot_len = wide ? BIT_W'(WORD_W) : BIT_W'(SAMPLE_W);
        k_full   = in_left ? bidx : (bidx - slot_len);
        k        = POS_W'(k_full);
        slot_top = wide ? POS_W'(WORD_W-1) : POS_W'(SAMPLE_W-1);
        pos      = lsb_first ? k : (slot_top - k);
        word     = wide ? {cur, {SAMPLE_W{1'b0}}} : {{SAMPLE_W{1'b0}}, cur};
        sdo      = word[pos];
    end
endmodule

// File: rtl/pcm_serial_tx.sv
// Module: programmable PCM serial transmitter (top). Divides the master clock
// into the bit clock, sequences frames and serializes stereo sample pairs.
// Assumes: configuration inputs and div are changed only under reset.
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int DIV_W    = DIV_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    div,
    input  logic                cfg_wide,
    input  logic                cfg_lsb_first,
    input  logic                cfg_sck_inv,
    input  logic                cfg_left_just,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                s_ready,
    output logic                sdo,
    output logic                sck,
    output logic                lrck
);
    localparam int BIT_W = $clog2(4*SAMPLE_W);

    pcm_cfg_t         cfg;
    logic             phase, bit_end, frame_end, in_left;
    logic [BIT_W-1:0] bidx;

    assign cfg     = '{wide: cfg_wide, lsb_first: cfg_lsb_first,
                       sck_inv: cfg_sck_inv, left_just: cfg_left_just};
    assign sck     = phase ^ cfg.sck_inv;
    assign s_ready = frame_end;

    pcm_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div(div),
        .phase(phase), .bit_end(bit_end)
    );

    pcm_frame_seq #(.SAMPLE_W(SAMPLE_W), .BIT_W(BIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_end(bit_end),
        .wide(cfg.wide), .left_just(cfg.left_just),
        .bidx(bidx), .in_left(in_left), .lrck(lrck), .frame_end(frame_end)
    );

    pcm_slot_mux #(.SAMPLE_W(SAMPLE_W), .BIT_W(BIT_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .load(frame_end), .take(s_valid),
        .left_in(s_left), .right_in(s_right), .bidx(bidx), .in_left(in_left),
        .wide(cfg.wide), .lsb_first(cfg.lsb_first), .sdo(sdo)
    );

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> !sdo); // R8
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.wide && !cfg.lsb_first &&
         ((bidx % BIT_W'(2*SAMPLE_W)) >= BIT_W'(SAMPLE_W))) |-> !sdo); // R9
endmodule

// File: tb/pcm_serial_tx_tb.sv
// Bench: directed scenarios, each resetting the transmitter under a new
// configuration and decoding four frames at the data-sampling clock edge.
module pcm_serial_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] div = '0;
    logic          cfg_wide = 1'b0, cfg_lsb_first = 1'b0;
    logic          cfg_sck_inv = 1'b0, cfg_left_just = 1'b0;
    logic          s_valid = 1'b0;
    logic [SW-1:0] s_left = '0, s_right = '0;
    logic          s_ready, sdo, sck, lrck;

    int cyc = 0;
    int n_vec = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcm_serial_tx #(.SAMPLE_W(SW), .DIV_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .div(div),
        .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first),
        .cfg_sck_inv(cfg_sck_inv), .cfg_left_just(cfg_left_just),
        .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
        .s_ready(s_ready), .sdo(sdo), .sck(sck), .lrck(lrck)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(logic [SW-1:0] x, int b, int s, bit lsb, bit wide);
        logic [2*SW-1:0] w;
        int k, pos;
        k   = b % s;
        pos = lsb ? k : s - 1 - k;
        w   = wide ? {x, {SW{1'b0}}} : {{SW{1'b0}}, x};
        return w[pos];
    endfunction

    function automatic logic exp_ws(int b, int s, bit lj);
        if (lj) return (b < s);
        return (b >= s - 1) && (b <= 2*s - 2);
    endfunction

    task automatic run_case(input int dv, input bit wide, input bit lsb, input bit inv,
                            input bit lj, input logic [SW-1:0] al, input logic [SW-1:0] ar,
                            input logic [SW-1:0] bl, input logic [SW-1:0] br);
        logic [SW-1:0] fl [4];
        logic [SW-1:0] fr [4];
        int s, last_cyc, rdy_cyc;
        logic prev_sck, prev_sdo, hit, samp;
        string tag;
        fl = '{16'h0, al, bl, 16'h0};
        fr = '{16'h0, ar, br, 16'h0};
        s  = wide ? 32 : 16;
        samp = ~inv;
        rst_n = 1'b0; s_valid = 1'b0;
        div = DW'(dv); cfg_wide = wide; cfg_lsb_first = lsb;
        cfg_sck_inv = inv; cfg_left_just = lj;
        repeat (4) @(negedge clk);
        check("R10", "sdo in reset", int'(sdo), 0);
        check("R10", "sck in reset", int'(sck), int'(inv));
        check("R10", "lrck in reset", int'(lrck), int'(lj));
        rst_n = 1'b1;
        fork
            begin
                s_valid = 1'b1; s_left = al; s_right = ar;
                do @(negedge clk); while (!s_ready);
                rdy_cyc = cyc;
                @(negedge clk);
                check("R7", "ready width", int'(s_ready), 0);
                s_left = bl; s_right = br;
                do @(negedge clk); while (!s_ready);
                check("R2", "frame length in cycles", cyc - rdy_cyc, 2*s*2*(1+dv));
                @(negedge clk);
                s_valid = 1'b0; s_left = '1; s_right = '1;
            end
            begin
                prev_sck = sck; prev_sdo = sdo; last_cyc = -1;
                for (int f = 0; f < 4; f++) begin
                    for (int b = 0; b < 2*s; b++) begin
                        do begin
                            @(negedge clk);
                            hit = (sck == samp) && (prev_sck != samp);
                            if (!hit) prev_sdo = sdo;
                            prev_sck = sck;
                        end while (!hit);
                        if (last_cyc >= 0) check("R1", "bit period", cyc - last_cyc, 2*(1+dv));
                        last_cyc = cyc;
                        check("R4", "sdo stable at sampling edge", int'(sdo), int'(prev_sdo));
                        if (f == 0 || f == 3) tag = (f == 0) ? "R10" : "R8";
                        else if (wide)        tag = "R9";
                        else if (lsb)         tag = "R3";
                        else                  tag = "R7";
                        check(tag, $sformatf("sdo frame %0d bit %0d", f, b), int'(sdo),
                              int'(exp_bit((b < s) ? fl[f] : fr[f], b, s, lsb, wide)));
                        check(lj ? "R6" : "R5", $sformatf("lrck frame %0d bit %0d", f, b),
                              int'(lrck), int'(exp_ws(b, s, lj)));
                        prev_sdo = sdo;
                    end
                end
            end
        join
    endtask

    // Scenario: I2S, 16-bit slots, MSB first, normal polarity.
    task automatic test_i2s_narrow_msb();
        run_case(1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h1E78, 16'h8001, 16'h7FFE);
    endtask

    // Scenario: left-justified, 16-bit slots, LSB first, inverted clock, fastest divider.
    task automatic test_lj_narrow_lsb_inv();
        run_case(0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0F31, 16'hC00D, 16'h5AA5, 16'h1234);
    endtask

    // Scenario: left-justified, 32-bit slots, MSB first.
    task automatic test_lj_wide_msb();
        run_case(3, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h8421, 16'h00F0, 16'hB00B);
    endtask

    // Scenario: I2S, 32-bit slots, LSB first, inverted clock.
    task automatic test_i2s_wide_lsb_inv();
        run_case(2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h6C93, 16'h0001, 16'hFEDC, 16'h3579);
    endtask

    initial begin
        test_i2s_narrow_msb();
        test_lj_narrow_lsb_inv();
        test_lj_wide_msb();
        test_i2s_wide_lsb_inv();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule